// File: doc/BRIEF.md
# Splittable Event Counter Bank

This block holds four physical event counters behind a small register bus. Each physical counter is either one 32-bit counter or two independent 16-bit halves, so software sees up to eight logical counters. Each logical counter has a control word that picks one line of a 64-wide event vector, can invert it, and chooses edge counting or active-cycle counting. A global control register enables the bank, freezes it, selects wrap or saturate behaviour, sets a privilege filter and picks the split per physical counter.

Counter values written by software are not applied to the running counters straight away. They are parked in a per-counter holding register and are applied on the next global-control write that has the enable bit set. Overflows set sticky status flags. A status read returns the flags and clears them. A status write loads the interrupt mask. The single interrupt line follows the masked flags.

Top module: `perf_ctr_bank`

## Requirements
- R1: After reset the global control, all control words, all counters, the status flags and the mask read as zero, and `irq` is low.
- R2: Logical counter k has its control word at address 8+k, with these fields: event select in bits 31:26, polarity invert in bit 24, count-cycles in bit 23, counter enable in bit 22. The event is the selected `ev_in` line XOR the polarity bit. With count-cycles clear, the counter adds one on every cycle where the event is high and was low on the previous cycle. With count-cycles set, it adds one on every cycle where the event is high.
- R3: Counting happens only while global control bit 31 is set and bit 20 (freeze) is clear. The 2-bit field at bits 19:18 must also be 3 (all modes) or equal `priv_mode` (0 supervisor, 1 hypervisor, 2 problem). Otherwise every counter holds its value.
- R4: Global control bit (24−n) splits physical counter n. Logical counter n is then bits 31:16 and logical counter n+4 is bits 15:0. Each half counts and wraps on its own, and neither carries into the other. When the counter is not split, only logical counter n drives the full 32 bits and logical n+4 has no effect.
- R5: Without saturation, a counter at all ones that is incremented goes to zero and sets status bit (31−k) for its logical counter k.
- R6: With global control bit 30 set, a counter stops at all ones. The increment that brings it to all ones sets its status flag, and later increments change nothing.
- R7: A write to address 4+n stores the value in a holding register, and reads of 4+n return the held value. The live count is replaced only by a global control write with bit 31 set, whether the bank was enabled before that write or not.
- R8: A write to address 1 loads the interrupt mask from bits 31:24, using the same bit-to-counter order as the flags. A read of address 1 returns the flags in bits 31:24 and clears them. An overflow that happens in the same cycle as the read stays set.
- R9: `irq` is high exactly while some status flag is set together with its mask bit.
- R10: With no value held, a read of 4+n returns the live count. Address 0 reads back the global control. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (has a side effect only on the status register) |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| ev_in | input | 64 | Event vector |
| priv_mode | input | 2 | Current privilege level used by the count-mode filter |
| irq | output | 1 | Overflow interrupt |

## Verification
The counters are first driven with slow hand-placed toggles on single event lines, so that edge counting and cycle counting give clearly different totals. The same hand-placed stimulus is then used with inverted polarity, and with freeze and privilege mismatches, which must leave the totals unchanged. Preloaded values just below the top of each width show whether wrap, saturation and half-independence are right, because a carry leaking between halves or a missing flag changes the count within a few cycles. A long phase with a pseudo-random event vector and changing control settings then looks for ordering errors between commit, counting and status clearing, which ordered patterns do not reach.

// File: rtl/pcb_pkg.sv
`timescale 1ns/1ps
package pcb_pkg;
  localparam int REG_W       = 32;
  // Register addresses
  localparam int ADDR_CTRL   = 0;
  localparam int ADDR_STAT   = 1;
  localparam int ADDR_CTR    = 4;
  localparam int ADDR_CW     = 8;
  // Global control bits
  localparam int G_ENABLE    = 31;
  localparam int G_SATURATE  = 30;
  localparam int G_FREEZE    = 20;
  localparam int G_MODE_HI   = 19;
  localparam int G_MODE_LO   = 18;
  localparam int G_SPLIT_TOP = 24;
  localparam logic [1:0] MODE_ANY = 2'd3;
  // Counter control word bits
  localparam int C_SEL_TOP   = 31;
  localparam int C_INVERT    = 24;
  localparam int C_CYCLES    = 23;
  localparam int C_ENABLE    = 22;
endpackage

// File: rtl/pcb_evt_sel.sv
`timescale 1ns/1ps
module pcb_evt_sel #(
  parameter int EV_W = 64,
  localparam int SEL_W = $clog2(EV_W)
) (
  input  logic [EV_W-1:0]  ev_now,
  input  logic [EV_W-1:0]  ev_prev,
  input  logic [SEL_W-1:0] sel,
  input  logic             invert,
  input  logic             cycles,
  input  logic             enable,
  input  logic             run,
  output logic             inc
);
  logic lvl_now;
  logic lvl_prev;

  always_comb begin
    lvl_now  = ev_now[sel]  ^ invert;
    lvl_prev = ev_prev[sel] ^ invert;
    inc      = run & enable & (cycles ? lvl_now : (lvl_now & ~lvl_prev));
  end
endmodule

// File: rtl/pcb_phys_ctr.sv
`timescale 1ns/1ps
module pcb_phys_ctr #(
  parameter int CTR_W = 32,
  localparam int HALF = CTR_W / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             split,
  input  logic             saturate,
  input  logic             inc_hi,
  input  logic             inc_lo,
  input  logic             park_we,
  input  logic [CTR_W-1:0] park_data,
  input  logic             commit,
  output logic [CTR_W-1:0] view,
  output logic             ovf_hi,
  output logic             ovf_lo
);
  localparam logic [CTR_W-1:0] F_NEAR = {{(CTR_W-1){1'b1}}, 1'b0};
  localparam logic [HALF-1:0]  H_NEAR = {{(HALF-1){1'b1}}, 1'b0};

  logic [CTR_W-1:0] live_q, live_d;
  logic [CTR_W-1:0] park_q;
  logic             held_q, held_d;
  logic [HALF-1:0]  hi_q, lo_q, hi_d, lo_d;
  logic             do_load;

  assign hi_q    = live_q[CTR_W-1:HALF];
  assign lo_q    = live_q[HALF-1:0];
  assign do_load = commit & held_q;

  // Next-state
  always_comb begin
    live_d = live_q;
    hi_d   = hi_q;
    lo_d   = lo_q;
    ovf_hi = 1'b0;
    ovf_lo = 1'b0;
    held_d = held_q;
    if (do_load) begin
      live_d = park_q;
      held_d = 1'b0;
    end else if (!split) begin
      if (inc_hi) begin
        if (saturate) begin
          if (!(&live_q)) live_d = live_q + 1'b1;
          ovf_hi = (live_q == F_NEAR);
        end else begin
          live_d = live_q + 1'b1;
          ovf_hi = &live_q;
        end
      end
    end else begin
      if (inc_hi) begin
        if (saturate) begin
          if (!(&hi_q)) hi_d = hi_q + 1'b1;
          ovf_hi = (hi_q == H_NEAR);
        end else begin
          hi_d   = hi_q + 1'b1;
          ovf_hi = &hi_q;
        end
      end
      if (inc_lo) begin
        if (saturate) begin
          if (!(&lo_q)) lo_d = lo_q + 1'b1;
          ovf_lo = (lo_q == H_NEAR);
        end else begin
          lo_d   = lo_q + 1'b1;
          ovf_lo = &lo_q;
        end
      end
      live_d = {hi_d, lo_d};
    end
    if (park_we) held_d = 1'b1;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
      held_q <= 1'b0;
    end else begin
      live_q <= live_d;
      held_q <= held_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       park_q <= '0;
    else if (park_we) park_q <= park_data;
  end

  assign view = held_q ? park_q : live_q;

  AST_PARK_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    park_we |=> view == $past(park_data)); // R7
  AST_COMMIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    do_load |=> live_q == $past(park_q)); // R7
  AST_HOLD_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (!split && saturate && (&live_q) && !do_load) |=> (&live_q)); // R6
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_hi && !inc_lo && !do_load) |=> $stable(live_q)); // R3
endmodule

// File: rtl/pcb_status.sv
`timescale 1ns/1ps
module pcb_status #(
  parameter int N_LOG = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_LOG-1:0] ovf,
  input  logic             rd_clr,
  input  logic             mask_we,
  input  logic [N_LOG-1:0] mask_data,
  output logic [N_LOG-1:0] pend,
  output logic             irq
);
  logic [N_LOG-1:0] pend_q, pend_d;
  logic [N_LOG-1:0] mask_q;

  always_comb pend_d = (rd_clr ? '0 : pend_q) | ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= mask_data;
  end

  assign pend = pend_q;
  assign irq  = |(pend_q & mask_q);

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && ovf == '0) |=> pend == '0); // R8
  AST_FLAG_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_clr) |=> (pend & $past(pend_q)) == $past(pend_q)); // R5
  AST_OVF_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf != '0) |=> (pend & $past(ovf)) == $past(ovf)); // R8
endmodule

// File: rtl/perf_ctr_bank.sv
`timescale 1ns/1ps
module perf_ctr_bank
  import pcb_pkg::*;
#(
  parameter int N_PHYS = 4,
  parameter int EV_W   = 64,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [EV_W-1:0]   ev_in,
  input  logic [1:0]        priv_mode,
  output logic              irq
);
  localparam int N_LOG = 2 * N_PHYS;
  localparam int SEL_W = $clog2(EV_W);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STAT);
  localparam logic [ADDR_W-1:0] A_CTR  = ADDR_W'(ADDR_CTR);
  localparam logic [ADDR_W-1:0] A_CW   = ADDR_W'(ADDR_CW);

  logic [REG_W-1:0] ctrl_q;
  logic [REG_W-1:0] cw_q [N_LOG];
  logic [EV_W-1:0]  ev_prev_q;
  logic [REG_W-1:0] ctr_view [N_PHYS];
  logic [N_LOG-1:0] inc, ovf, pend, mask_data, cw_we;
  logic [N_PHYS-1:0] park_we;
  logic [REG_W-1:0] stat_word;
  logic             ctrl_we, stat_we, stat_rd, commit, run;
  logic [1:0]       mode;

  // Bus decode
  assign ctrl_we = bus_wr & (bus_addr == A_CTRL);
  assign stat_we = bus_wr & (bus_addr == A_STAT);
  assign stat_rd = bus_rd & (bus_addr == A_STAT);
  assign commit  = ctrl_we & bus_wdata[G_ENABLE];

  // Gating
  assign mode = ctrl_q[G_MODE_HI:G_MODE_LO];
  assign run  = ctrl_q[G_ENABLE] & ~ctrl_q[G_FREEZE] &
                ((mode == MODE_ANY) | (mode == priv_mode));

  // Global control and previous event vector
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ev_prev_q <= '0;
    else        ev_prev_q <= ev_in;
  end

  // Logical counters: control words and event selection
  for (genvar k = 0; k < N_LOG; k++) begin : g_log
    assign cw_we[k] = bus_wr & (bus_addr == A_CW + ADDR_W'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cw_q[k] <= '0;
      else if (cw_we[k])  cw_q[k] <= bus_wdata;
    end

    pcb_evt_sel #(.EV_W(EV_W)) u_sel (
      .ev_now (ev_in),
      .ev_prev(ev_prev_q),
      .sel    (cw_q[k][C_SEL_TOP -: SEL_W]),
      .invert (cw_q[k][C_INVERT]),
      .cycles (cw_q[k][C_CYCLES]),
      .enable (cw_q[k][C_ENABLE]),
      .run    (run),
      .inc    (inc[k])
    );

    assign mask_data[k] = bus_wdata[REG_W-1-k];
  end

  // Physical counters
  for (genvar n = 0; n < N_PHYS; n++) begin : g_phys
    assign park_we[n] = bus_wr & (bus_addr == A_CTR + ADDR_W'(n));

    pcb_phys_ctr #(.CTR_W(REG_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .split    (ctrl_q[G_SPLIT_TOP - n]),
      .saturate (ctrl_q[G_SATURATE]),
      .inc_hi   (inc[n]),
      .inc_lo   (inc[n + N_PHYS]),
      .park_we  (park_we[n]),
      .park_data(bus_wdata),
      .commit   (commit),
      .view     (ctr_view[n]),
      .ovf_hi   (ovf[n]),
      .ovf_lo   (ovf[n + N_PHYS])
    );
  end

  pcb_status #(.N_LOG(N_LOG)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .ovf      (ovf),
    .rd_clr   (stat_rd),
    .mask_we  (stat_we),
    .mask_data(mask_data),
    .pend     (pend),
    .irq      (irq)
  );

  // Read mux
  always_comb begin
    stat_word = '0;
    for (int k = 0; k < N_LOG; k++) stat_word[REG_W-1-k] = pend[k];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CTRL) bus_rdata = ctrl_q;
    if (bus_addr == A_STAT) bus_rdata = stat_word;
    for (int n = 0; n < N_PHYS; n++)
      if (bus_addr == A_CTR + ADDR_W'(n)) bus_rdata = ctr_view[n];
    for (int k = 0; k < N_LOG; k++)
      if (bus_addr == A_CW + ADDR_W'(k)) bus_rdata = cw_q[k];
  end

  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[G_FREEZE] |-> inc == '0); // R3
  AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[G_ENABLE] |-> inc == '0); // R3
  AST_OVF_NEEDS_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf & ~inc) == '0); // R5
endmodule

// File: tb/tb_perf_ctr_bank.sv
`timescale 1ns/1ps
module tb_perf_ctr_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [63:0] ev_in;
  logic [1:0]  priv_mode;
  logic        irq;

  int    checks = 0;
  int    fails  = 0;
  bit    chk_on = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  perf_ctr_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_in(ev_in), .priv_mode(priv_mode), .irq(irq)
  );

  localparam logic [31:0] EN   = 32'h8000_0000;
  localparam logic [31:0] SAT  = 32'h4000_0000;
  localparam logic [31:0] FRZ  = 32'h0010_0000;
  localparam logic [31:0] MALL = 32'h000C_0000;

  function automatic logic [31:0] split_bit(int n);
    return 32'h1 << (24 - n);
  endfunction

  function automatic logic [31:0] cw(int sel, bit cyc, bit inv, bit en);
    return (32'(sel) << 26) | (32'(inv) << 24) | (32'(cyc) << 23) | (32'(en) << 22);
  endfunction

  // Behavioural reference model
  logic [31:0] m_ctrl;
  logic [31:0] m_cw   [8];
  logic [31:0] m_live [4];
  logic [31:0] m_park [4];
  logic [3:0]  m_held;
  logic [7:0]  m_flag, m_mask;
  logic [63:0] m_evp;

  function automatic longint step(longint v, longint top, bit sat, bit inc, output bit ov);
    ov = 0;
    if (!inc) return v;
    if (sat) begin
      if (v == top - 1) ov = 1;
      if (v != top) return v + 1;
      return v;
    end
    if (v == top) begin ov = 1; return 0; end
    return v + 1;
  endfunction

  function automatic logic [31:0] exp_rd(logic [4:0] a);
    logic [31:0] r;
    r = 0;
    if (a == 0) r = m_ctrl;
    else if (a == 1) begin
      for (int k = 0; k < 8; k++) r[31-k] = m_flag[k];
    end else if (a >= 4 && a < 8) r = m_held[a-4] ? m_park[a-4] : m_live[a-4];
    else if (a >= 8 && a < 16) r = m_cw[a-8];
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    logic [7:0] inc, nov;
    logic run;
    logic [1:0] md;
    bit o1, o2;
    longint hv, lv, fv;
    if (!rst_n) begin
      m_ctrl = 0; m_held = 0; m_flag = 0; m_mask = 0; m_evp = 0;
      for (int i = 0; i < 8; i++) m_cw[i] = 0;
      for (int i = 0; i < 4; i++) begin m_live[i] = 0; m_park[i] = 0; end
    end else begin
      md  = m_ctrl[19:18];
      run = m_ctrl[31] && !m_ctrl[20] && (md == 3 || md == priv_mode);
      for (int k = 0; k < 8; k++) begin
        logic [5:0] s;
        logic ln, lp;
        s = m_cw[k][31:26];
        ln = ev_in[s] ^ m_cw[k][24];
        lp = m_evp[s] ^ m_cw[k][24];
        inc[k] = run && m_cw[k][22] && (m_cw[k][23] ? ln : (ln && !lp));
      end
      nov = 0;
      for (int n = 0; n < 4; n++) begin
        if (bus_wr && bus_addr == 0 && bus_wdata[31] && m_held[n]) begin
          m_live[n] = m_park[n]; m_held[n] = 0;
        end else if (m_ctrl[24-n]) begin
          hv = step(longint'(m_live[n][31:16]), 65535, m_ctrl[30], inc[n], o1);
          lv = step(longint'(m_live[n][15:0]), 65535, m_ctrl[30], inc[n+4], o2);
          m_live[n] = {hv[15:0], lv[15:0]};
          nov[n] = o1; nov[n+4] = o2;
        end else begin
          fv = step(longint'(m_live[n]), 64'hFFFF_FFFF, m_ctrl[30], inc[n], o1);
          m_live[n] = fv[31:0];
          nov[n] = o1;
        end
      end
      m_flag = ((bus_rd && bus_addr == 1) ? 8'h00 : m_flag) | nov;
      if (bus_wr) begin
        if (bus_addr == 0) m_ctrl = bus_wdata;
        else if (bus_addr == 1) for (int k = 0; k < 8; k++) m_mask[k] = bus_wdata[31-k];
        else if (bus_addr >= 4 && bus_addr < 8) begin
          m_park[bus_addr-4] = bus_wdata; m_held[bus_addr-4] = 1;
        end else if (bus_addr >= 8 && bus_addr < 16) m_cw[bus_addr-8] = bus_wdata;
      end
      m_evp = ev_in;
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && chk_on) begin
      checks++;
      if (irq !== (|(m_flag & m_mask))) begin
        fails++;
        $display("FAIL %s R9 irq: got %b expected %b", cur_req, irq, |(m_flag & m_mask));
      end
      checks++;
      if (bus_rdata !== exp_rd(bus_addr)) begin
        fails++;
        $display("FAIL %s rdata addr %0d: got %h expected %h", cur_req, bus_addr, bus_rdata, exp_rd(bus_addr));
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(logic [4:0] a, logic [31:0] d);
    @(negedge clk); #1;
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic bus_read(logic [4:0] a);
    logic [31:0] e;
    @(negedge clk); #1;
    bus_rd = 1; bus_addr = a;
    #1;
    e = exp_rd(a);
    checks++;
    if (bus_rdata !== e) begin
      fails++;
      $display("FAIL %s read addr %0d: got %h expected %h", cur_req, a, bus_rdata, e);
    end
    @(negedge clk); #1;
    bus_rd = 0;
  endtask

  task automatic set_ev(int bitn, logic v);
    @(negedge clk); #1;
    ev_in[bitn] = v;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [63:0] x;
    rst_n = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    ev_in = 0; priv_mode = 0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    // R1: reset state
    @(negedge clk);
    checks++;
    if (irq !== 1'b0 || bus_rdata !== 32'h0) begin
      fails++;
      $display("FAIL R1 reset: got irq %b data %h expected 0 00000000", irq, bus_rdata);
    end
    chk_on = 1;
    cur_req = "R1";
    bus_read(0); bus_read(1); bus_read(4); bus_read(9); bus_read(20);

    // R2: edge counting and inverted cycle counting
    cur_req = "R2";
    bus_write(8, cw(5, 0, 0, 1));
    bus_write(9, cw(10, 1, 1, 1));
    bus_write(0, EN | MALL);
    for (int i = 0; i < 4; i++) begin
      set_ev(5, 1); idle(2); set_ev(5, 0); idle(1);
    end
    set_ev(10, 1); idle(3); set_ev(10, 0); idle(2);
    bus_read(4); bus_read(5);

    // R3: freeze and privilege filter
    cur_req = "R3";
    bus_write(0, EN | MALL | FRZ);
    set_ev(5, 1); idle(2); set_ev(5, 0); idle(2);
    bus_read(4); bus_read(5);
    priv_mode = 2;
    bus_write(0, EN | 32'h0004_0000);
    set_ev(5, 1); idle(2); set_ev(5, 0); idle(2);
    bus_read(4);
    priv_mode = 1;
    set_ev(5, 1); idle(2); set_ev(5, 0); idle(2);
    bus_read(4); bus_read(5);

    // R7: writes parked while disabled
    cur_req = "R7";
    bus_write(0, MALL);
    bus_write(6, 32'hFFF0_FFFA);
    bus_read(6);
    bus_write(4, 32'hFFFF_FFFD);
    idle(3);
    bus_read(4);

    // R4 / R5: split counter and wrap, commit on enable
    cur_req = "R4";
    bus_write(10, cw(3, 1, 0, 1));
    bus_write(14, cw(4, 1, 0, 1));
    bus_write(8, cw(3, 1, 0, 1));
    bus_write(12, cw(3, 1, 0, 1));
    bus_write(1, 32'hFF00_0000);
    bus_write(0, EN | MALL | split_bit(2));
    set_ev(3, 1); set_ev(4, 1);
    idle(8);
    bus_read(6); bus_read(4);
    cur_req = "R5";
    bus_read(1);
    bus_read(1);
    set_ev(4, 0);
    idle(3);
    bus_read(6);

    // R7 / R10: parked while enabled, commit by rewriting control
    cur_req = "R7";
    bus_write(7, 32'h0000_1234);
    bus_read(7);
    idle(2);
    bus_write(0, EN | MALL | split_bit(2));
    cur_req = "R10";
    bus_read(7); bus_read(4); bus_read(0);

    // R6: saturation
    cur_req = "R6";
    bus_write(9, cw(3, 1, 0, 1));
    bus_write(5, 32'hFFFF_FFFB);
    bus_write(0, EN | SAT | MALL | split_bit(2));
    idle(10);
    bus_read(5);
    bus_read(1);
    idle(4);
    bus_read(1);
    bus_read(5);

    // R8 / R9: partial mask
    cur_req = "R8";
    bus_write(1, 32'h4000_0000);
    bus_write(5, 32'hFFFF_FFFE);
    bus_write(0, EN | MALL);
    idle(3);
    bus_read(1);
    cur_req = "R9";
    bus_write(1, 32'h0000_0000);
    idle(2);

    // Mixed phase with pseudo-random events (R2, R3, R4, R5, R8)
    cur_req = "R2";
    x = 64'h9E37_79B9_7F4A_7C15;
    bus_write(1, 32'hFF00_0000);
    for (int k = 0; k < 8; k++) bus_write(5'(8 + k), cw((k * 7) % 64, k[0], k[1], 1));
    for (int r = 0; r < 6; r++) begin
      bus_write(5'(4 + (r % 4)), 32'hFFFF_FF00 ^ (32'(r) << 20));
      bus_write(0, EN | MALL | (r[0] ? SAT : 32'h0) | (r[1] ? split_bit(r % 4) : 32'h0) |
                (r == 4 ? split_bit(0) | split_bit(3) : 32'h0));
      for (int c = 0; c < 60; c++) begin
        @(negedge clk); #1;
        x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
        ev_in = x;
        priv_mode = x[1:0] == 2'd3 ? 2'd0 : x[1:0];
      end
      bus_read(1);
      bus_read(5'(4 + r % 4));
    end

    chk_on = 0;
    idle(1);
    summary();
    $finish;
  end
endmodule